// File: doc/BRIEF.md
# Cascaded Post Divider with Phase Sync

This block derives an output clock from a fast clock through three programmable divider stages in series. The overall division ratio is the product of the three stage moduli. The high time of the output is always exactly half of its period, including odd ratios, because the waveform is built at half-period resolution from one flop clocked on each edge of the fast clock. The inverted copy of the output is driven alongside it.

An optional sync input lets a system re-phase the output to an external event. When sync is enabled, the edge of the sync signal opposite to the selected polarity requests a stop. The stop takes effect only at the end of the running output period, so the output parks low and never emits a shortened pulse. The selected edge then restarts the output. Its first rising edge follows the sync edge after a fixed latency, quantised to half a fast-clock period. A stage code outside the legal range falls back to a ratio of one for that stage and raises an error flag.

Top module: `cascade_postdiv`

## Requirements
- R1: The output period is N fast-clock periods, where N is the product of the three stage moduli. `clk_out_n` is always the complement of `clk_out`.
- R2: A first or second stage code c in 0 to 11 selects a stage modulus of c+1.
- R3: A third stage code of 0, 1, 2 or 3 selects a stage modulus of 1, 2, 4 or 8 respectively.
- R4: The output high time is exactly N/2 fast-clock periods for odd and even N. For N = 1 the output toggles on both fast-clock edges.
- R5: A first or second stage code from 12 to 15 makes that stage's modulus 1 and drives `code_err` high. With legal codes on both stages, `code_err` is low.
- R6: With `sync_en` low, the sync input has no effect and the output keeps running at its programmed period.
- R7: With `sync_en` high, an inactive sync edge stops the output. The inactive edge is falling when `sync_pol` is 1 and rising when it is 0. The stop lands at the end of the current output period, the last high pulse has full width, and the output then stays low.
- R8: While the output is stopped, an active sync edge restarts it. The first rising output edge falls on the first fast-clock edge, rising or falling, that lies more than three fast-clock periods after the sync edge. Full-width periods follow.
- R9: With `sync_pol` = 1 the rising sync edge is the active one. With `sync_pol` = 0 the falling sync edge is the active one.
- R10: `rst_n` is an asynchronous active-low reset. While it is low, `clk_out` is 0 and `clk_out_n` is 1. After release the output runs freely without any sync event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast source clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage1_code | input | 4 | First stage code (modulus code+1, 12..15 reserved) |
| stage2_code | input | 4 | Second stage code (modulus code+1, 12..15 reserved) |
| stage3_code | input | 2 | Third stage code (modulus 1, 2, 4, 8) |
| sync_en | input | 1 | Enables stop and restart by the sync input |
| sync_pol | input | 1 | 1: rising sync edge restarts; 0: falling edge restarts |
| sync_in | input | 1 | Asynchronous phase sync signal |
| clk_out | output | 1 | Divided clock |
| clk_out_n | output | 1 | Complement of the divided clock |
| code_err | output | 1 | High while a reserved stage code is applied |

## Verification
The hardest condition to reach is the half-period restart choice. The block picks between a restart on a falling fast-clock edge and one on a rising edge, depending on which half of the fast-clock cycle the sync edge arrives in. The bench parks the output first, then places the active sync edge one time unit after a rising fast-clock edge in one run and one time unit after a falling edge in another. It checks that both runs give the same measured delay from the sync edge to the first output rise. Both sync polarities pass through the same stop-and-restart sequence with an odd ratio, so that the half-period path is in use.

// File: rtl/pd_pkg.sv
`timescale 1ns/1ps
package pd_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_STOP = 2'd1,
      ST_ARM  = 2'd2
   } pd_state_e;
endpackage

// File: rtl/pd_stage_decode.sv
`timescale 1ns/1ps
// Converts a stage code into a modulus; POW2 selects the power-of-two variant.
module pd_stage_decode #(
   parameter int CODE_W  = 4,
   parameter int MAX_MOD = 12,
   parameter bit POW2    = 1'b0,
   parameter int MOD_W   = 4
) (
   input  logic [CODE_W-1:0] code,
   output logic [MOD_W-1:0]  modulus,
   output logic              reserved
);
   generate
      if (POW2) begin : g_pow2
         always_comb begin
            modulus  = MOD_W'(1) << code;
            reserved = 1'b0;
         end
      end else begin : g_lin
         always_comb begin
            reserved = (int'(code) >= MAX_MOD);
            modulus  = reserved ? MOD_W'(1) : (MOD_W'(code) + MOD_W'(1));
         end
      end
   endgenerate
endmodule

// File: rtl/pd_sync_edge.sv
`timescale 1ns/1ps
// Synchronises the sync input on both fast-clock edges and reports edges
// normalised to the selected polarity, plus which half-cycle saw it first.
module pd_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_raw,
   input  logic active_high,
   output logic act_edge,
   output logic inact_edge,
   output logic early
);
   logic [STAGES:0]   pos_q;
   logic [STAGES-1:0] neg_q;
   logic              early_q;
   logic              cur_lvl, prv_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         early_q <= 1'b0;
      end else begin
         pos_q   <= {pos_q[STAGES-1:0], sync_raw};
         early_q <= neg_q[STAGES-1];
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) neg_q <= '0;
      else        neg_q <= {neg_q[STAGES-2:0], sync_raw};
   end

   always_comb begin
      cur_lvl    = pos_q[STAGES-1] ^ ~active_high;
      prv_lvl    = pos_q[STAGES]   ^ ~active_high;
      act_edge   = cur_lvl & ~prv_lvl;
      inact_edge = ~cur_lvl & prv_lvl;
      early      = early_q ^ ~active_high;
   end
endmodule

// File: rtl/pd_wave_gen.sv
`timescale 1ns/1ps
// Period counter, stop/restart control and dual-edge waveform register pair.
module pd_wave_gen
   import pd_pkg::*;
#(
   parameter int TOT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TOT_W-1:0] modulus,
   input  logic             sync_en,
   input  logic             act_edge,
   input  logic             inact_edge,
   input  logic             early,
   output logic             wave,
   output pd_state_e        state,
   output logic [TOT_W-1:0] cnt
);
   localparam int IW = TOT_W + 1;

   pd_state_e        st_q, st_d;
   logic [TOT_W-1:0] cnt_q, cnt_d;
   logic             ph_q, ph_d, stop_q, stop_d, last;
   logic             p_q, n_q;

   // Half-slot index within the output period; high for the first N slots.
   function automatic logic slot_high(input logic [TOT_W-1:0] c, input logic ph,
                                      input logic neg, input logic [TOT_W-1:0] m);
      logic [IW-1:0] c2, idx;
      c2 = {c, 1'b0};
      if (!ph)      idx = neg ? (c2 + IW'(1)) : c2;
      else if (neg) idx = c2;
      else          idx = (c == '0) ? ({m, 1'b0} - IW'(1)) : (c2 - IW'(1));
      return idx < {1'b0, m};
   endfunction

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      ph_d   = ph_q;
      stop_d = stop_q;
      last   = (cnt_q >= (modulus - TOT_W'(1)));
      unique case (st_q)
         ST_RUN: begin
            cnt_d = last ? '0 : (cnt_q + TOT_W'(1));
            if (!sync_en)        stop_d = 1'b0;
            else if (inact_edge) stop_d = 1'b1;
            if (stop_q && sync_en && last) begin
               st_d   = ST_STOP;
               stop_d = 1'b0;
               cnt_d  = '0;
               ph_d   = 1'b0;
            end
         end
         ST_STOP: begin
            cnt_d = '0;
            if (!sync_en) begin
               st_d = ST_RUN;
               ph_d = 1'b0;
            end else if (act_edge) begin
               if (early) begin
                  st_d = ST_RUN;
                  ph_d = 1'b1;
               end else begin
                  st_d = ST_ARM;
               end
            end
         end
         ST_ARM: begin
            st_d  = ST_RUN;
            ph_d  = 1'b0;
            cnt_d = '0;
         end
         default: st_d = ST_STOP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_RUN;
         cnt_q  <= '0;
         ph_q   <= 1'b0;
         stop_q <= 1'b0;
         p_q    <= 1'b0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         ph_q   <= ph_d;
         stop_q <= stop_d;
         p_q    <= ((st_d == ST_RUN) & slot_high(cnt_d, ph_d, 1'b0, modulus)) ^ n_q;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) n_q <= 1'b0;
      else        n_q <= ((st_q == ST_RUN) & slot_high(cnt_q, ph_q, 1'b1, modulus)) ^ p_q;
   end

   assign wave  = p_q ^ n_q;
   assign state = st_q;
   assign cnt   = cnt_q;
endmodule

// File: rtl/cascade_postdiv.sv
`timescale 1ns/1ps
module cascade_postdiv
   import pd_pkg::*;
#(
   parameter int CODE_W      = 4,
   parameter int LAST_W      = 2,
   parameter int MAX_MOD     = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_fast,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] stage1_code,
   input  logic [CODE_W-1:0] stage2_code,
   input  logic [LAST_W-1:0] stage3_code,
   input  logic              sync_en,
   input  logic              sync_pol,
   input  logic              sync_in,
   output logic              clk_out,
   output logic              clk_out_n,
   output logic              code_err
);
   localparam int MOD_W    = $clog2(MAX_MOD + 1);
   localparam int LAST_MAX = 1 << ((1 << LAST_W) - 1);
   localparam int LAST_MW  = $clog2(LAST_MAX + 1);
   localparam int TOT_MAX  = MAX_MOD * MAX_MOD * LAST_MAX;
   localparam int TOT_W    = $clog2(TOT_MAX + 1);

   generate
      if (MAX_MOD > (1 << CODE_W)) begin : g_bad_code
         $error("MAX_MOD does not fit in CODE_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [CODE_W-1:0]  lin_code [2];
   logic [MOD_W-1:0]   lin_mod  [2];
   logic [1:0]         lin_res;
   logic [LAST_MW-1:0] last_mod;
   logic               last_res;
   logic [TOT_W-1:0]   mod_total;
   logic               act_edge, inact_edge, early, wave;
   pd_state_e          state;
   logic [TOT_W-1:0]   cnt;

   assign lin_code[0] = stage1_code;
   assign lin_code[1] = stage2_code;

   generate
      for (genvar gi = 0; gi < 2; gi++) begin : g_lin_stage
         pd_stage_decode #(.CODE_W(CODE_W), .MAX_MOD(MAX_MOD), .POW2(1'b0), .MOD_W(MOD_W)) u_dec (
            .code(lin_code[gi]), .modulus(lin_mod[gi]), .reserved(lin_res[gi]));
      end
   endgenerate

   pd_stage_decode #(.CODE_W(LAST_W), .MAX_MOD(LAST_MAX), .POW2(1'b1), .MOD_W(LAST_MW)) u_dec_last (
      .code(stage3_code), .modulus(last_mod), .reserved(last_res));

   assign mod_total = TOT_W'(lin_mod[0]) * TOT_W'(lin_mod[1]) * TOT_W'(last_mod);
   assign code_err  = |lin_res | last_res;

   pd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk_fast), .rst_n(rst_n), .sync_raw(sync_in), .active_high(sync_pol),
      .act_edge(act_edge), .inact_edge(inact_edge), .early(early));

   pd_wave_gen #(.TOT_W(TOT_W)) u_wave (
      .clk(clk_fast), .rst_n(rst_n), .modulus(mod_total), .sync_en(sync_en),
      .act_edge(act_edge), .inact_edge(inact_edge), .early(early),
      .wave(wave), .state(state), .cnt(cnt));

   assign clk_out   = wave;
   assign clk_out_n = ~wave;
endmodule

// File: rtl/pd_checker.sv
`timescale 1ns/1ps
module pd_checker
   import pd_pkg::*;
#(
   parameter int CODE_W  = 4,
   parameter int MAX_MOD = 12,
   parameter int MOD_W   = 4,
   parameter int TOT_W   = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_out,
   input logic              sync_en,
   input logic [CODE_W-1:0] stage1_code,
   input logic [MOD_W-1:0]  mod1,
   input logic [TOT_W-1:0]  mod_total,
   input pd_state_e         state,
   input logic [TOT_W-1:0]  cnt
);
   // R7
   stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STOP) |-> !clk_out);
   // R7
   stop_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STOP && $past(state) == ST_RUN) |-> ($past(cnt) >= ($past(mod_total) - TOT_W'(1))));
   // R8
   arm_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ARM) |=> (state == ST_RUN));
   // R6
   en_off_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_en && state == ST_RUN) |=> (state == ST_RUN));
   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |=> (cnt < $past(mod_total)));
   // R5
   reserved_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(stage1_code) >= MAX_MOD) |-> (mod1 == MOD_W'(1)));
endmodule

bind cascade_postdiv pd_checker #(.CODE_W(CODE_W), .MAX_MOD(MAX_MOD), .MOD_W(MOD_W), .TOT_W(TOT_W)) u_pd_chk (
   .clk(clk_fast), .rst_n(rst_n), .clk_out(clk_out), .sync_en(sync_en),
   .stage1_code(stage1_code), .mod1(lin_mod[0]), .mod_total(mod_total),
   .state(state), .cnt(cnt));

// File: tb/cascade_postdiv_test.sv
`timescale 1ns/1ps
module cascade_postdiv_test;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] s1 = 4'd1, s2 = 4'd0;
   logic [1:0] s3 = 2'd0;
   logic       sen = 1'b0, spol = 1'b1, sin = 1'b0;
   logic       co, con, cerr;

   int tests = 0, fails = 0;
   longint last_rise = 0, last_period = 0, last_high = 0, mark_time = 0;
   int     rise_cnt = 0;
   bit     have_rise = 0, mark_armed = 0;

   always #(CLK_P/2) clk = ~clk;

   cascade_postdiv uut (
      .clk_fast(clk), .rst_n(rst_n), .stage1_code(s1), .stage2_code(s2), .stage3_code(s3),
      .sync_en(sen), .sync_pol(spol), .sync_in(sin),
      .clk_out(co), .clk_out_n(con), .code_err(cerr));

   always @(posedge co) begin
      if (have_rise) last_period = $time - last_rise;
      last_rise = $time;
      have_rise = 1;
      rise_cnt++;
      if (mark_armed) begin
         mark_time  = $time;
         mark_armed = 0;
      end
   end
   always @(negedge co) last_high = $time - last_rise;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int lin_mod(input int c);
      return (c > 11) ? 1 : c + 1;
   endfunction

   task automatic t_reset();
      #3;
      chk(co == 1'b0, "R10", "clk_out in reset", co, 0);
      chk(con == 1'b1, "R10", "clk_out_n in reset", con, 1);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (12) @(posedge clk);
      #2;
      chk(last_period == 2*CLK_P, "R10", "free-run period after reset", last_period, 2*CLK_P);
   endtask

   task automatic t_div(input int c1, input int c2, input int c3, input string req);
      int n;
      bit err;
      n   = lin_mod(c1) * lin_mod(c2) * (1 << c3);
      err = (c1 > 11) || (c2 > 11);
      @(posedge clk);
      #1;
      s1 = 4'(c1); s2 = 4'(c2); s3 = 2'(c3);
      repeat (3*n + 6) @(posedge clk);
      #2;
      chk(last_period == longint'(n*CLK_P), req, "period", last_period, n*CLK_P);
      chk(last_high == longint'(n*CLK_P/2), "R4", "high time", last_high, n*CLK_P/2);
      chk(con == ~co, "R1", "complement output", con, ~co);
      chk(cerr == err, "R5", "code_err", cerr, err);
   endtask

   task automatic t_sync_off();
      int rc0;
      @(posedge clk); #1;
      s1 = 4'd2; s2 = 4'd0; s3 = 2'd0; sen = 1'b0; spol = 1'b1;
      repeat (12) @(posedge clk);
      rc0 = rise_cnt;
      for (int i = 0; i < 6; i++) begin
         repeat (5) @(posedge clk);
         #1 sin = ~sin;
      end
      repeat (4) @(posedge clk);
      #2;
      chk(rise_cnt - rc0 >= 10, "R6", "rises with sync disabled", rise_cnt - rc0, 10);
      chk(last_period == 3*CLK_P, "R6", "period with sync disabled", last_period, 3*CLK_P);
   endtask

   task automatic t_stop_restart(input bit pol, input bit late);
      int     rc0;
      longint t0;
      @(posedge clk); #1;
      sen = 1'b0; spol = pol; sin = pol;
      s1 = 4'd2; s2 = 4'd0; s3 = 2'd0;
      repeat (10) @(posedge clk); #1 sen = 1'b1;
      repeat (10) @(posedge clk); #1 sin = ~pol;
      repeat (30) @(posedge clk);
      #2;
      rc0 = rise_cnt;
      chk(last_high == 15, "R7", "last pulse before stop", last_high, 15);
      repeat (20) @(posedge clk);
      #2;
      chk(rise_cnt == rc0, "R7", "no rises while stopped", rise_cnt, rc0);
      chk(co == 1'b0, "R7", "parked level", co, 0);
      @(posedge clk);
      #(late ? 6 : 1);
      t0 = $time;
      mark_armed = 1;
      sin = pol;
      repeat (10) @(posedge clk);
      #2;
      chk(mark_time - t0 == 34, pol ? "R8" : "R9", "restart latency", mark_time - t0, 34);
      repeat (12) @(posedge clk);
      #2;
      chk(last_period == 3*CLK_P, "R8", "period after restart", last_period, 3*CLK_P);
      chk(last_high == 15, "R8", "high after restart", last_high, 15);
      @(posedge clk); #1 sen = 1'b0;
   endtask

   initial begin
      t_reset();
      t_div(1, 0, 0, "R1");
      t_div(2, 0, 0, "R4");
      t_div(0, 0, 0, "R4");
      t_div(11, 0, 0, "R2");
      t_div(4, 2, 0, "R2");
      t_div(0, 0, 3, "R3");
      t_div(2, 1, 2, "R3");
      t_div(13, 2, 1, "R5");
      t_div(0, 15, 0, "R5");
      t_div(10, 11, 3, "R1");
      t_sync_off();
      t_stop_restart(1'b1, 1'b0);
      t_stop_restart(1'b1, 1'b1);
      t_stop_restart(1'b0, 1'b0);
      t_stop_restart(1'b0, 1'b1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_P*150000);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule